// File: doc/BRIEF.md
# PLL Divider Reprogramming Sequencer

This block holds the control word of a clock synthesizer and changes its divider settings without letting a glitched or unlocked clock reach downstream logic. A single request carries a new feedback multiplier code and a new post-divider code. The block compares the requested multiplier with the one already in force and then picks one of two paths. If the multiplier changes, the path is a full relock: route the reference around the loop, hold the loop in reset, load both codes, release reset, then wait for the coarse lock indicator and after it the fine one. If only the post-divider changes, the path is a short update done under bypass, with no reset and no lock wait.

Four single commands are also accepted while idle. The first starts the loop and waits for lock. The second puts the loop back into reset. The last two turn the clock output on and off. The block also reports the nominal output frequency, worked out from a reference frequency input and the control word.

Top module: `pll_reprog_seq`

## Requirements
- R1: After synchronous reset the control word reads 0x0000_0006: reset bit 2 = 1, external bypass bit 1 = 1, all other bits 0. busy, done and err are 0.
- R2: A request whose multiplier code differs from the current one produces these control words in this order, each held for exactly one cycle. Bypass (bit 1) is set first. Then reset (bit 2) is set. Then the multiplier code (bits 27:20) and the post-divider code (bits 18:16) are loaded while reset is 1. Then reset is cleared. The multiplier field changes only while both reset and bypass are 1.
- R3: After reset is released, the sequencer waits for lock_first and only then for lock_second. lock_second alone does not end the wait.
- R4: When a relock finishes, bit 0 (output enable) is set, bypass is cleared and done pulses. busy is 0 in the cycle done is 1.
- R5: A request with an unchanged multiplier code sets bypass, then loads only the post-divider field, then clears bypass and pulses done. Reset stays 0 throughout. The post-divider field changes only while bypass is 1.
- R6: out_rate equals ref_rate × (multiplier + 1) / 2^post-divider, the division being a right shift. While bypass is 1, out_rate equals ref_rate.
- R7: cmd_prepare clears reset, waits for lock_first then lock_second, and then pulses done. Bypass and enable are left unchanged.
- R8: While idle, cmd_unprepare sets bit 2, cmd_enable sets bit 0 and cmd_disable clears bit 0. Each takes effect at the next clock edge without raising busy. When several are present, the order of precedence is request, prepare, unprepare, enable, disable.
- R9: Requests and commands that arrive while busy is 1 are ignored.
- R10: done is high for exactly one cycle for each completed sequence.
- R11: If a lock wait lasts more than tmo_limit cycles without the awaited lock, err is set, the block returns to idle and bypass is 1. err is cleared when the next request or prepare is accepted.
- R12: Bits 28 and 29 of the control word show lock_first and lock_second directly. Bits 12:8, 6:4 and 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request pulse carrying new divider codes |
| req_fb | input | 8 | Requested feedback multiplier code |
| req_od | input | 3 | Requested post-divider code (power-of-two exponent) |
| cmd_prepare | input | 1 | Release loop reset and wait for lock |
| cmd_unprepare | input | 1 | Put loop into reset |
| cmd_enable | input | 1 | Set output enable |
| cmd_disable | input | 1 | Clear output enable |
| lock_first | input | 1 | Coarse lock indicator from the loop |
| lock_second | input | 1 | Later, fine lock indicator from the loop |
| tmo_limit | input | TMO_W | Cycles allowed per lock wait |
| ref_rate | input | REF_W | Reference frequency value |
| ctrl_reg | output | 32 | Control word driven to the loop |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when a sequence completes |
| err | output | 1 | Lock wait timed out |
| out_rate | output | REF_W+9 | Nominal output frequency |

## Verification
The assertions assume that tmo_limit and ref_rate stay constant while a sequence runs. They also assume that the lock inputs come from a loop that drops both indicators while it is held in reset. The bench's lock model clears its lock counter whenever bit 2 is set and raises the two indicators at programmable delays once reset is released. tmo_limit is changed only while the block is idle. The model's delays are reordered or made unreachable on purpose to cover the ordering and timeout cases.

// File: rtl/pll_seq_pkg.sv
// Shared field positions and sequencer states for the PLL reprogramming block.
// Assumes a 32-bit control word; positions that the loop decodes are fixed here.
package pll_seq_pkg;
    localparam int REG_W     = 32;
    localparam int FB_W      = 8;
    localparam int OD_W      = 3;
    localparam int FB_LSB    = 20;
    localparam int OD_LSB    = 16;
    localparam int RST_BIT   = 2;
    localparam int XBYP_BIT  = 1;
    localparam int EN_BIT    = 0;
    localparam int LOCK1_BIT = 28;
    localparam int LOCK2_BIT = 29;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RL_RST,
        S_RL_DIV,
        S_RL_REL,
        S_WAIT1,
        S_WAIT2,
        S_BY_DIV,
        S_BY_END
    } seq_state_t;
endpackage

// File: rtl/pll_lock_timer.sv
// Timeout counter for one lock wait.
// Counts cycles while active and the awaited lock is absent; restarts on lock
// or when inactive. Assumes limit is stable during a wait.
module pll_lock_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             lock,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    localparam logic [TMO_W-1:0] CNT_MAX = '1;

    logic [TMO_W-1:0] cnt;

    // Count waiting cycles, saturating, cleared outside a wait or on lock.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || lock) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Expiry when the wait has lasted past the limit without the lock.
    assign expired = active && !lock && (cnt >= limit);

    AST_EXPIRE_LEAVES_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        expired |=> !active); // R11
endmodule

// File: rtl/pll_rate_calc.sv
// Nominal output frequency from the reference and the divider fields.
// Bypass returns the reference unchanged; otherwise ref*(fb+1) >> od.
module pll_rate_calc
    import pll_seq_pkg::*;
#(
    parameter int REF_W = 32
) (
    input  logic [REF_W-1:0]        ref_rate,
    input  logic [FB_W-1:0]         fb,
    input  logic [OD_W-1:0]         od,
    input  logic                    bypass,
    output logic [REF_W+FB_W:0]     rate
);
    localparam int OUT_W = REF_W + FB_W + 1;

    logic [FB_W:0]     fb_plus;
    logic [OUT_W-1:0]  prod;

    // Multiply by the loop factor and shift by the post-divider exponent.
    always_comb begin
        fb_plus = {1'b0, fb} + {{FB_W{1'b0}}, 1'b1};
        prod    = OUT_W'(ref_rate) * OUT_W'(fb_plus);
        rate    = bypass ? OUT_W'(ref_rate) : (prod >> od);
    end
endmodule

// File: rtl/pll_reprog_seq.sv
// Top of the PLL reprogramming sequencer.
// Owns the control word, picks a relock or a bypass-only sequence per request,
// waits on two lock indicators in order with a timeout, and reports the rate.
// Assumes lock inputs drop while loop reset is asserted.
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int REF_W = 32,
    parameter int TMO_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [FB_W-1:0]       req_fb,
    input  logic [OD_W-1:0]       req_od,
    input  logic                  cmd_prepare,
    input  logic                  cmd_unprepare,
    input  logic                  cmd_enable,
    input  logic                  cmd_disable,
    input  logic                  lock_first,
    input  logic                  lock_second,
    input  logic [TMO_W-1:0]      tmo_limit,
    input  logic [REF_W-1:0]      ref_rate,
    output logic [REG_W-1:0]      ctrl_reg,
    output logic                  busy,
    output logic                  done,
    output logic                  err,
    output logic [REF_W+FB_W:0]   out_rate
);
    seq_state_t      state;
    logic [FB_W-1:0] fb_q, tgt_fb;
    logic [OD_W-1:0] od_q, tgt_od;
    logic            rst_q, byp_q, en_q;
    logic            prep_mode, done_q, err_q;
    logic            waiting, cur_lock, expired;

    // Select the lock indicator the current wait state observes.
    always_comb begin
        waiting  = (state == S_WAIT1) || (state == S_WAIT2);
        cur_lock = (state == S_WAIT1) ? lock_first : lock_second;
    end

    pll_lock_timer #(.TMO_W(TMO_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (waiting),
        .lock    (cur_lock),
        .limit   (tmo_limit),
        .expired (expired)
    );

    // Sequencer: one control-word write per step, each held at least a cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            fb_q      <= '0;
            od_q      <= '0;
            tgt_fb    <= '0;
            tgt_od    <= '0;
            rst_q     <= 1'b1;
            byp_q     <= 1'b1;
            en_q      <= 1'b0;
            prep_mode <= 1'b0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        tgt_fb    <= req_fb;
                        tgt_od    <= req_od;
                        byp_q     <= 1'b1;
                        err_q     <= 1'b0;
                        prep_mode <= 1'b0;
                        state     <= (req_fb != fb_q) ? S_RL_RST : S_BY_DIV;
                    end else if (cmd_prepare) begin
                        rst_q     <= 1'b0;
                        err_q     <= 1'b0;
                        prep_mode <= 1'b1;
                        state     <= S_WAIT1;
                    end else if (cmd_unprepare) begin
                        rst_q <= 1'b1;
                    end else if (cmd_enable) begin
                        en_q <= 1'b1;
                    end else if (cmd_disable) begin
                        en_q <= 1'b0;
                    end
                end
                S_RL_RST: begin
                    rst_q <= 1'b1;
                    state <= S_RL_DIV;
                end
                S_RL_DIV: begin
                    fb_q  <= tgt_fb;
                    od_q  <= tgt_od;
                    state <= S_RL_REL;
                end
                S_RL_REL: begin
                    rst_q <= 1'b0;
                    state <= S_WAIT1;
                end
                S_WAIT1: begin
                    if (lock_first) begin
                        state <= S_WAIT2;
                    end else if (expired) begin
                        err_q <= 1'b1;
                        byp_q <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_WAIT2: begin
                    if (lock_second) begin
                        if (!prep_mode) begin
                            en_q  <= 1'b1;
                            byp_q <= 1'b0;
                        end
                        done_q <= 1'b1;
                        state  <= S_IDLE;
                    end else if (expired) begin
                        err_q <= 1'b1;
                        byp_q <= 1'b1;
                        state <= S_IDLE;
                    end
                end
                S_BY_DIV: begin
                    od_q  <= tgt_od;
                    state <= S_BY_END;
                end
                S_BY_END: begin
                    byp_q  <= 1'b0;
                    done_q <= 1'b1;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Assemble the control word from held fields and live lock status.
    always_comb begin
        ctrl_reg                     = '0;
        ctrl_reg[LOCK2_BIT]          = lock_second;
        ctrl_reg[LOCK1_BIT]          = lock_first;
        ctrl_reg[FB_LSB +: FB_W]     = fb_q;
        ctrl_reg[OD_LSB +: OD_W]     = od_q;
        ctrl_reg[RST_BIT]            = rst_q;
        ctrl_reg[XBYP_BIT]           = byp_q;
        ctrl_reg[EN_BIT]             = en_q;
    end

    assign busy = (state != S_IDLE);
    assign done = done_q;
    assign err  = err_q;

    pll_rate_calc #(.REF_W(REF_W)) u_rate (
        .ref_rate (ref_rate),
        .fb       (fb_q),
        .od       (od_q),
        .bypass   (byp_q),
        .rate     (out_rate)
    );

    AST_FB_UNDER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fb_q) |-> (rst_q && byp_q)); // R2
    AST_OD_UNDER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(od_q) |-> byp_q); // R5
    AST_LOCK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT2 && $past(state) == S_WAIT1) |-> $past(lock_first)); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R10
    AST_ERR_BYPASSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> byp_q); // R11
endmodule

// File: tb/sim_pll_reprog_seq.sv
module sim_pll_reprog_seq;
    localparam int REF_W = 32;
    localparam int TMO_W = 16;
    localparam int OUT_W = REF_W + 9;
    localparam logic [REF_W-1:0] REF = 32'd25_000_000;
    localparam int NVEC = 6;
    // Each vector: {multiplier[11:4], post-divider[3:1], expect relock[0]}
    localparam logic [11:0] VEC [NVEC] = '{
        {8'h20, 3'd1, 1'b1},
        {8'h20, 3'd3, 1'b0},
        {8'h55, 3'd0, 1'b1},
        {8'h55, 3'd7, 1'b0},
        {8'hFF, 3'd2, 1'b1},
        {8'h00, 3'd5, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0, cmd_prepare = 0, cmd_unprepare = 0, cmd_enable = 0, cmd_disable = 0;
    logic [7:0] req_fb = '0;
    logic [2:0] req_od = '0;
    logic lock_first, lock_second;
    logic [TMO_W-1:0] tmo_limit = 16'd50;
    logic [31:0] ctrl_reg;
    logic busy, done, err;
    logic [OUT_W-1:0] out_rate;

    int checks = 0, errors = 0;
    int da = 3, db = 5;
    int lock_cnt = 0;
    int cycles = 0;
    int done_cnt = 0;
    bit saw_rst = 0;

    always #10 clk = ~clk; // 50 MHz

    pll_reprog_seq #(.REF_W(REF_W), .TMO_W(TMO_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fb(req_fb), .req_od(req_od),
        .cmd_prepare(cmd_prepare), .cmd_unprepare(cmd_unprepare), .cmd_enable(cmd_enable),
        .cmd_disable(cmd_disable), .lock_first(lock_first), .lock_second(lock_second),
        .tmo_limit(tmo_limit), .ref_rate(REF), .ctrl_reg(ctrl_reg), .busy(busy),
        .done(done), .err(err), .out_rate(out_rate)
    );

    // Lock model: counts cycles since loop reset was released.
    always @(posedge clk) begin
        if (!rst_n || ctrl_reg[2]) lock_cnt <= 0;
        else if (lock_cnt < 200000) lock_cnt <= lock_cnt + 1;
    end
    assign lock_first  = (lock_cnt >= da);
    assign lock_second = (lock_cnt >= db);

    // Monitor: done pulses and reset activity during a sequence.
    always @(negedge clk) begin
        if (done) done_cnt++;
        if (busy && ctrl_reg[2]) saw_rst = 1;
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input logic [7:0] fb, input logic [2:0] od);
        @(negedge clk);
        req_fb = fb; req_od = od; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000; i++) begin
            if (!busy) return;
            @(negedge clk);
        end
        check(0, "wait_idle timeout", 1, 0);
    endtask

    initial begin
        logic [31:0] exp_reg;
        logic [OUT_W-1:0] exp_rate;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(ctrl_reg == 32'h6, "R1 ctrl", ctrl_reg, 32'h6);
        check(!busy && !done && !err, "R1 flags", {busy, done, err}, 0);
        check(out_rate == OUT_W'(REF), "R6 bypass rate at reset", out_rate, REF);
        rst_n = 1;
        @(negedge clk);
        check(ctrl_reg[29:28] == 2'b00, "R12 lock bits low in reset", ctrl_reg[29:28], 0);

        // R7 prepare
        done_cnt = 0;
        @(negedge clk); cmd_prepare = 1;
        @(negedge clk); cmd_prepare = 0;
        check(busy && ctrl_reg[2] == 0, "R7 prepare releases reset", {busy, ctrl_reg[2]}, 2'b10);
        wait_idle();
        @(negedge clk);
        check(done_cnt == 1, "R7 done once", done_cnt, 1);
        check(ctrl_reg == 32'h3000_0002, "R7/R12 word after prepare", ctrl_reg, 32'h3000_0002);

        // R8 enable
        @(negedge clk); cmd_enable = 1;
        @(negedge clk); cmd_enable = 0;
        check(ctrl_reg[0] == 1 && !busy, "R8 enable", {ctrl_reg[0], busy}, 2'b10);

        // R2 step-by-step relock sequence
        @(negedge clk); req_fb = 8'h10; req_od = 3'd2; req_valid = 1;
        @(negedge clk); req_valid = 0;
        check(ctrl_reg[2:1] == 2'b01 && ctrl_reg[27:20] == 0, "R2 step1 bypass", ctrl_reg, 32'h3000_0003);
        check(out_rate == OUT_W'(REF), "R6 bypass rate", out_rate, REF);
        @(negedge clk);
        check(ctrl_reg[2:1] == 2'b11 && ctrl_reg[27:20] == 0, "R2 step2 reset", ctrl_reg, 32'h0000_0007);
        @(negedge clk);
        check(ctrl_reg[27:16] == 12'h102 && ctrl_reg[2:1] == 2'b11, "R2 step3 fields", ctrl_reg, 32'h0102_0007);
        @(negedge clk);
        check(ctrl_reg[2:1] == 2'b01 && ctrl_reg[27:16] == 12'h102, "R2 step4 release", ctrl_reg, 32'h0102_0003);
        wait_idle();
        check(ctrl_reg[1:0] == 2'b01 && done, "R4 finish enable/bypass/done", {ctrl_reg[1:0], done}, 3'b011);

        // Table walk: R2/R5/R6/R10
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] vf;
            logic [2:0] vo;
            bit vr;
            vf = VEC[i][11:4]; vo = VEC[i][3:1]; vr = VEC[i][0];
            @(negedge clk);
            done_cnt = 0; saw_rst = 0;
            pulse_req(vf, vo);
            wait_idle();
            repeat (2) @(negedge clk);
            exp_reg = 32'h3000_0001 | (32'(vf) << 20) | (32'(vo) << 16);
            exp_rate = (OUT_W'(REF) * OUT_W'({1'b0, vf} + 9'd1)) >> vo;
            check(ctrl_reg == exp_reg, "R2/R5 final word", ctrl_reg, exp_reg);
            check(out_rate == exp_rate, "R6 rate", out_rate, exp_rate);
            check(saw_rst == vr, "R2/R5 path choice", saw_rst, vr);
            check(done_cnt == 1, "R10 single done", done_cnt, 1);
        end

        // R5 step-by-step bypass-only update (state fb=0, od=5)
        @(negedge clk); req_fb = 8'h00; req_od = 3'd6; req_valid = 1;
        @(negedge clk); req_valid = 0;
        check(ctrl_reg[2:1] == 2'b01 && ctrl_reg[18:16] == 3'd5, "R5 step1", ctrl_reg, 32'h3005_0003);
        @(negedge clk);
        check(ctrl_reg[2:1] == 2'b01 && ctrl_reg[18:16] == 3'd6, "R5 step2", ctrl_reg, 32'h3006_0003);
        @(negedge clk);
        check(ctrl_reg[2:1] == 2'b00 && done && !busy, "R5 step3", {ctrl_reg[2:1], done, busy}, 4'b0010);

        // R9 requests while busy ignored
        pulse_req(8'h40, 3'd1);
        repeat (2) @(negedge clk);
        pulse_req(8'h41, 3'd4);
        @(negedge clk); cmd_disable = 1;
        @(negedge clk); cmd_disable = 0;
        wait_idle();
        repeat (3) @(negedge clk);
        check(ctrl_reg[27:16] == 12'h401 && !busy, "R9 busy request ignored", ctrl_reg[27:16], 12'h401);
        check(ctrl_reg[0] == 1, "R9 busy command ignored", ctrl_reg[0], 1);

        // R3 lock order: second lock arrives first
        da = 20; db = 2;
        done_cnt = 0;
        pulse_req(8'h50, 3'd0);
        for (int i = 0; i < 20 && ctrl_reg[2:1] != 2'b01; i++) @(negedge clk);
        while (ctrl_reg[2]) @(negedge clk);
        repeat (10) @(negedge clk);
        check(busy && lock_second && !lock_first, "R3 waits for first lock", {busy, lock_second, lock_first}, 3'b110);
        wait_idle();
        @(negedge clk);
        check(done_cnt == 1 && ctrl_reg[27:20] == 8'h50, "R3 completes after first lock", done_cnt, 1);
        da = 3; db = 5;

        // R11 timeout
        da = 1000000; tmo_limit = 16'd10; done_cnt = 0;
        pulse_req(8'h60, 3'd0);
        wait_idle();
        @(negedge clk);
        check(err && ctrl_reg[1] && done_cnt == 0, "R11 timeout err/bypass", {err, ctrl_reg[1], done_cnt[0]}, 3'b110);
        da = 3; tmo_limit = 16'd50;
        pulse_req(8'h61, 3'd0);
        wait_idle();
        @(negedge clk);
        check(!err && ctrl_reg[1:0] == 2'b01, "R11 err cleared by request", {err, ctrl_reg[1:0]}, 3'b001);

        // R8 unprepare / disable
        @(negedge clk); cmd_unprepare = 1;
        @(negedge clk); cmd_unprepare = 0;
        check(ctrl_reg[2] == 1 && !busy, "R8 unprepare", {ctrl_reg[2], busy}, 2'b10);
        @(negedge clk); cmd_disable = 1;
        @(negedge clk); cmd_disable = 0;
        check(ctrl_reg[0] == 0 && !busy, "R8 disable", {ctrl_reg[0], busy}, 2'b00);
        check(ctrl_reg[12:3] == 0, "R12 unused fields zero", ctrl_reg[12:3], 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule